// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM Model

This block is a synthesizable model of a flow-through synchronous SRAM. It can alternate reads and writes on consecutive clocks without inserting idle cycles. Address, command and byte strobes are registered on the rising clock edge. Read data flows combinationally out of the array during the cycle that follows the edge that took the read. Write data lags its command by one clock. Because of that lag, the data bus never has to turn around between a write command and a read command.

A two-bit burst counter lets one supplied address serve up to four accesses. A static mode pin chooses the burst order: linear, where the counter is added to the two low address bits, or interleaved, where the counter is XORed into them.

The model also has:
- a clock enable that freezes the whole cycle;
- three chip selects, all of which must agree for an access to happen;
- an output enable that is not clocked;
- a sleep input.

High impedance is represented by the `dq_drive` flag together with a zeroed `dq_out`.

The control is a four-state machine. Its states are:
- IDLE: nothing selected.
- READ: a read beat is in progress.
- WRITE: the data phase of a write beat.
- SLEEP: the sleep input is held.

Its transitions are:
- LOAD_RD: enabled edge, selected, `burst_cont`=0, `wr_en`=0, to READ.
- LOAD_WR: the same with `wr_en`=1, to WRITE.
- DESELECT: enabled edge, `burst_cont`=0, not selected, to IDLE.
- CONTINUE: enabled edge, `burst_cont`=1. From READ or WRITE it stays in the same state and the beat count is incremented. From IDLE it stays in IDLE.
- STALL: `clk_en`=0. Every state holds.
- ENTER_SLEEP: any edge with `sleep`=1, to SLEEP.
- WAKE: enabled edge with `sleep`=0 in SLEEP, to IDLE. The command presented on that edge is ignored.

Top module: `zbt_flow_sram`

## Requirements
- R1: An access is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. A load (`burst_cont`=0) seen on an enabled edge with any other combination performs neither a read nor a write, and leaves `dq_drive`=0.
- R2: A write writes byte lane i (bits 8i+7..8i of `wdata`) only when bit i of `byte_we`, registered with the command, is 1. A mask of 0 changes nothing.
- R3: A selected read load with `wr_en`=0 makes `dq_out` equal to the stored word at `addr`, with `dq_drive`=1 when `out_en`=1, in the cycle after the edge.
- R4: Write data is captured on the next enabled edge after the write command. A read of the same address loaded on that edge returns the new data, with no idle cycle in between.
- R5: `burst_cont`=1 continues the current operation and increments a two-bit beat count modulo 4, starting at 0 on a load. The beat address keeps `addr` bits above bit 1. Its low two bits are base+beat mod 4 when `seq_ilv`=0 and base XOR beat when `seq_ilv`=1.
- R6: `burst_cont`=1 while IDLE is a no-operation: no read, no write, `dq_drive`=0.
- R7: During the data phase of a write, `dq_drive`=0 regardless of `out_en`.
- R8: `out_en`=0 forces `dq_drive`=0 at once, without waiting for a clock edge.
- R9: An edge with `clk_en`=0 is ignored. State, burst count and outputs are unchanged, and a pending write keeps waiting: its data is taken on the next enabled edge.
- R10: While `sleep`=1, `dq_drive`=0. The first enabled edge after `sleep` falls ignores its command and leaves the outputs undriven.
- R11: After reset the block is IDLE with `dq_drive`=0.
- R12: `dq_out` is all zeros whenever `dq_drive`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; 0 makes the edge a stall |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| wr_en | input | 1 | 1 = write command, 0 = read command |
| burst_cont | input | 1 | 0 = load a new address, 1 = continue the burst |
| byte_we | input | LANES | Per-lane write strobes |
| addr | input | ADDR_W | Word address |
| seq_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| out_en | input | 1 | Unclocked output enable, active high |
| sleep | input | 1 | Sleep request |
| wdata | input | LANES*LANE_W | Write data, presented one cycle after its command |
| dq_out | output | LANES*LANE_W | Read data, zero when not driving |
| dq_drive | output | 1 | 1 when the outputs drive, 0 for high impedance |

## Verification
The bench sweeps every address in a write-then-read chain with no gaps. A design that delayed commit, or that failed to forward a fresh write, would return the previous word there. Every base address is then run through four-beat bursts in both orders. A design that carried into bit 2, or that confused XOR with addition, would read the wrong word on specific beats. Stalls are inserted inside a pending write and inside a read, and deselect and continue-from-idle are combined with write strobes. Each of these would show up either as a corrupted stored word on read-back or as data changing during a frozen cycle. The bench also toggles output enable and sleep between edges, because a clocked gate would leave `dq_drive` high until the next edge.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } sram_state_e;

    localparam int BEAT_W = 2;

endpackage

// File: rtl/zbt_ctrl_fsm.sv
`timescale 1ns/1ps
module zbt_ctrl_fsm
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_en,
    input  logic                 sleep,
    input  logic                 sel,
    input  logic                 adv,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [LANES-1:0]     byte_we,
    output sram_state_e          state,
    output logic [ADDR_W-1:0]    base_addr,
    output logic [BEAT_W-1:0]    beat,
    output logic [LANES-1:0]     lane_we,
    output logic                 commit
);

    sram_state_e             nxt_state;
    logic [ADDR_W-1:0]       nxt_base;
    logic [BEAT_W-1:0]       nxt_beat;
    logic [LANES-1:0]        nxt_lane_we;

    // next-state and command capture
    always_comb begin
        nxt_state   = state;
        nxt_base    = base_addr;
        nxt_beat    = beat;
        nxt_lane_we = lane_we;
        if (sleep) begin
            nxt_state = ST_SLEEP;                       // ENTER_SLEEP
        end else if (clk_en) begin
            unique case (state)
                ST_SLEEP: nxt_state = ST_IDLE;          // WAKE
                ST_IDLE, ST_READ, ST_WRITE: begin
                    if (!adv) begin
                        if (sel) begin                  // LOAD_RD / LOAD_WR
                            nxt_state   = wr ? ST_WRITE : ST_READ;
                            nxt_base    = addr;
                            nxt_beat    = '0;
                            nxt_lane_we = byte_we;
                        end else begin
                            nxt_state   = ST_IDLE;      // DESELECT
                        end
                    end else if (state != ST_IDLE) begin
                        nxt_beat = beat + 2'd1;         // CONTINUE
                    end
                end
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            base_addr <= '0;
            beat      <= '0;
            lane_we   <= '0;
        end else begin
            state     <= nxt_state;
            base_addr <= nxt_base;
            beat      <= nxt_beat;
            lane_we   <= nxt_lane_we;
        end
    end

    // a write data phase completes on the next enabled edge
    always_comb begin
        commit = clk_en && (state == ST_WRITE);
    end

endmodule

// File: rtl/zbt_burst_addr.sv
`timescale 1ns/1ps
module zbt_burst_addr
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [BEAT_W-1:0] beat,
    input  logic              seq_ilv,
    output logic [ADDR_W-1:0] beat_addr
);

    logic [BEAT_W-1:0] low;

    always_comb begin
        if (seq_ilv) low = base_addr[BEAT_W-1:0] ^ beat;
        else         low = base_addr[BEAT_W-1:0] + beat;
        beat_addr = {base_addr[ADDR_W-1:BEAT_W], low};
    end

endmodule

// File: rtl/zbt_lane_array.sv
`timescale 1ns/1ps
module zbt_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                      clk,
    input  logic                      commit,
    input  logic [LANES-1:0]          lane_we,
    input  logic [ADDR_W-1:0]         word_addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (commit && lane_we[g]) begin
                cells[word_addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[word_addr];
    end

endmodule

// File: rtl/zbt_flow_sram.sv
`timescale 1ns/1ps
module zbt_flow_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clk_en,
    input  logic                      cs0_n,
    input  logic                      cs1,
    input  logic                      cs2_n,
    input  logic                      wr_en,
    input  logic                      burst_cont,
    input  logic [LANES-1:0]          byte_we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      seq_ilv,
    input  logic                      out_en,
    input  logic                      sleep,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   dq_out,
    output logic                      dq_drive
);

    sram_state_e              fsm_state;
    logic [ADDR_W-1:0]        base_addr;
    logic [ADDR_W-1:0]        cur_addr;
    logic [BEAT_W-1:0]        beat;
    logic [LANES-1:0]         lane_we;
    logic                     commit;
    logic                     sel_all;
    logic [LANES*LANE_W-1:0]  array_word;

    assign sel_all = !cs0_n && cs1 && !cs2_n;

    zbt_ctrl_fsm #(.ADDR_W(ADDR_W), .LANES(LANES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .sleep     (sleep),
        .sel       (sel_all),
        .adv       (burst_cont),
        .wr        (wr_en),
        .addr      (addr),
        .byte_we   (byte_we),
        .state     (fsm_state),
        .base_addr (base_addr),
        .beat      (beat),
        .lane_we   (lane_we),
        .commit    (commit)
    );

    zbt_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .base_addr (base_addr),
        .beat      (beat),
        .seq_ilv   (seq_ilv),
        .beat_addr (cur_addr)
    );

    zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .commit    (commit),
        .lane_we   (lane_we),
        .word_addr (cur_addr),
        .wdata     (wdata),
        .rdata     (array_word)
    );

    // output process: unclocked gating by output enable and sleep
    always_comb begin
        dq_drive = out_en && !sleep && (fsm_state == ST_READ);
        dq_out   = dq_drive ? array_word : '0;
    end

endmodule

// File: rtl/zbt_sram_chk.sv
`timescale 1ns/1ps
module zbt_sram_chk
    import sram_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_en,
    input  logic               sleep,
    input  logic               out_en,
    input  logic               adv,
    input  logic               sel,
    input  sram_state_e        state,
    input  logic [BEAT_W-1:0]  beat,
    input  logic               dq_drive
);

    // R7
    write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |-> !dq_drive);

    // R8
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !dq_drive);

    // R10
    sleep_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep || $past(sleep)) |-> !dq_drive);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !sleep) |=> ($stable(state) && $stable(beat)));

    // R5
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sleep && adv && (state == ST_READ || state == ST_WRITE))
        |=> (beat == $past(beat) + 2'd1));

    // R1
    desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sleep && !adv && !sel && state != ST_SLEEP)
        |=> (state == ST_IDLE));

    // R6
    cont_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sleep && adv && state == ST_IDLE) |=> (state == ST_IDLE));

endmodule

bind zbt_flow_sram zbt_sram_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .sleep    (sleep),
    .out_en   (out_en),
    .adv      (burst_cont),
    .sel      (sel_all),
    .state    (fsm_state),
    .beat     (beat),
    .dq_drive (dq_drive)
);

// File: tb/zbt_flow_sram_tb.sv
`timescale 1ns/1ps
module zbt_flow_sram_tb;

    localparam int AW    = 6;
    localparam int NB    = 4;
    localparam int LW    = 8;
    localparam int DW    = NB*LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n, clk_en, cs0_n, cs1, cs2_n, wr_en, burst_cont;
    logic [NB-1:0] byte_we;
    logic [AW-1:0] addr;
    logic          seq_ilv, out_en, sleep;
    logic [DW-1:0] wdata, dq_out;
    logic          dq_drive;

    logic [DW-1:0] ref_mem [DEPTH];
    int            n_vec = 0;
    int            n_bad = 0;

    always #2.5 clk = ~clk;

    zbt_flow_sram #(.ADDR_W(AW), .LANES(NB), .LANE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cs0_n(cs0_n), .cs1(cs1),
        .cs2_n(cs2_n), .wr_en(wr_en), .burst_cont(burst_cont), .byte_we(byte_we),
        .addr(addr), .seq_ilv(seq_ilv), .out_en(out_en), .sleep(sleep),
        .wdata(wdata), .dq_out(dq_out), .dq_drive(dq_drive)
    );

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cmd(bit sel_ok, bit wr, bit cont, logic [NB-1:0] bwe, logic [AW-1:0] a);
        {cs0_n, cs1, cs2_n} = sel_ok ? 3'b010 : 3'b101;
        wr_en      = wr;
        burst_cont = cont;
        byte_we    = bwe;
        addr       = a;
    endtask

    function automatic logic [DW-1:0] pat(int a);
        return 32'(32'h9E3779B9 * 32'(a + 1)) ^ 32'(a);
    endfunction

    function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, int k, bit ilv);
        logic [1:0] lo;
        lo = ilv ? (b[1:0] ^ 2'(k)) : (b[1:0] + 2'(k));
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NB-1:0] m);
        logic [DW-1:0] r;
        r = old;
        for (int i = 0; i < NB; i++) if (m[i]) r[i*LW +: LW] = nw[i*LW +: LW];
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clk_en = 1'b1; seq_ilv = 1'b0; out_en = 1'b1; sleep = 1'b0;
        wdata = '0;
        cmd(0, 0, 0, '0, '0);
        repeat (3) step();
        check("R11 drive after reset", 32'(dq_drive), 32'd0);
        check("R12 data after reset", dq_out, '0);
        rst_n = 1'b1;
        step();

        // R3 R4 R7: write then read every address back to back
        for (int a = 0; a < DEPTH; a++) begin
            cmd(1, 1, 0, 4'hF, 6'(a));
            step();
            check("R7 write phase drive", 32'(dq_drive), 32'd0);
            wdata = pat(a);
            ref_mem[a] = pat(a);
            cmd(1, 0, 0, '0, 6'(a));
            step();
            check("R4 read after write", dq_out, ref_mem[a]);
            check("R3 read drive", 32'(dq_drive), 32'd1);
        end

        // R2: every byte mask
        for (int a = 0; a < 16; a++) begin
            cmd(1, 1, 0, 4'(a), 6'(a));
            step();
            wdata = ~pat(a);
            ref_mem[a] = merge(ref_mem[a], ~pat(a), 4'(a));
            cmd(1, 0, 0, '0, 6'(a));
            step();
            check("R2 byte lanes", dq_out, ref_mem[a]);
        end

        // R5: read bursts from every base in both orders
        for (int m = 0; m < 2; m++) begin
            seq_ilv = m[0];
            for (int b = 0; b < DEPTH; b++) begin
                cmd(1, 0, 0, '0, 6'(b));
                step();
                check("R5 burst beat0", dq_out, ref_mem[b]);
                for (int k = 1; k < 4; k++) begin
                    cmd(0, 0, 1, '0, '0);
                    step();
                    check(m ? "R5 interleaved beat" : "R5 linear beat",
                          dq_out, ref_mem[beat_addr(6'(b), k, m[0])]);
                end
            end
        end

        // R5: interleaved write burst from base 21, then read back
        seq_ilv = 1'b1;
        cmd(1, 1, 0, 4'hF, 6'd21);
        step();
        for (int k = 1; k < 4; k++) begin
            wdata = 32'hC0DE_0000 + 32'(k - 1);
            ref_mem[beat_addr(6'd21, k - 1, 1'b1)] = wdata;
            cmd(0, 1, 1, 4'h0, '0);
            step();
            check("R7 burst write drive", 32'(dq_drive), 32'd0);
        end
        wdata = 32'hC0DE_0003;
        ref_mem[beat_addr(6'd21, 3, 1'b1)] = wdata;
        cmd(1, 0, 0, '0, 6'd21);
        step();
        check("R5 write burst readback", dq_out, ref_mem[21]);
        for (int k = 1; k < 4; k++) begin
            cmd(1, 0, 0, '0, beat_addr(6'd21, k, 1'b1));
            step();
            check("R5 write burst readback", dq_out, ref_mem[beat_addr(6'd21, k, 1'b1)]);
        end
        seq_ilv = 1'b0;

        // R1 R6: deselect combinations, then continue from idle
        for (int c = 0; c < 8; c++) begin
            if (c == 2) continue;
            {cs0_n, cs1, cs2_n} = 3'(c);
            wr_en = 1'b1; burst_cont = 1'b0; byte_we = 4'hF; addr = 6'd5;
            step();
            check("R1 deselect drive", 32'(dq_drive), 32'd0);
            wdata = 32'hDEAD_BEEF;
            burst_cont = 1'b1;
            step();
            check("R6 continue from idle drive", 32'(dq_drive), 32'd0);
            wdata = 32'hBAD0_0BAD;
            cmd(1, 0, 0, '0, 6'd5);
            step();
            check("R1 R6 no write", dq_out, ref_mem[5]);
        end

        // R8 R12: unclocked output enable
        cmd(1, 0, 0, '0, 6'd9);
        step();
        check("R3 read before oe", dq_out, ref_mem[9]);
        out_en = 1'b0;
        #1;
        check("R8 oe off drive", 32'(dq_drive), 32'd0);
        check("R12 oe off data", dq_out, '0);
        out_en = 1'b1;
        #1;
        check("R8 oe back on", dq_out, ref_mem[9]);

        // R9: stall during a read and during a pending write
        cmd(1, 0, 0, '0, 6'd12);
        step();
        clk_en = 1'b0;
        cmd(1, 0, 0, '0, 6'd13);
        step();
        check("R9 stall holds read", dq_out, ref_mem[12]);
        step();
        check("R9 stall holds read", dq_out, ref_mem[12]);
        clk_en = 1'b1;
        step();
        check("R9 read after stall", dq_out, ref_mem[13]);
        cmd(1, 1, 0, 4'hF, 6'd30);
        step();
        clk_en = 1'b0;
        wdata = 32'h1111_1111;
        cmd(1, 0, 0, '0, 6'd30);
        step();
        check("R9 stalled write phase drive", 32'(dq_drive), 32'd0);
        clk_en = 1'b1;
        wdata = 32'h2468_ACE0;
        ref_mem[30] = 32'h2468_ACE0;
        step();
        check("R9 write held across stall", dq_out, ref_mem[30]);

        // R10: sleep
        cmd(1, 0, 0, '0, 6'd33);
        step();
        check("R3 read before sleep", 32'(dq_drive), 32'd1);
        sleep = 1'b1;
        #1;
        check("R10 sleep drive", 32'(dq_drive), 32'd0);
        step();
        step();
        check("R10 sleep held drive", 32'(dq_drive), 32'd0);
        sleep = 1'b0;
        cmd(1, 0, 0, '0, 6'd34);
        #1;
        check("R10 sleep release drive", 32'(dq_drive), 32'd0);
        step();
        check("R10 wake edge drive", 32'(dq_drive), 32'd0);
        step();
        check("R10 read after wake", dq_out, ref_mem[34]);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule